// File: doc/BRIEF.md
# SPI Shift Engine with Master Output Delay

This block moves bytes over a four-wire serial link, as either the clock source (master) or the clock follower (slave). Software works it through three byte-wide registers: a receive buffer, a transmit buffer and a control/status register. Writing the transmit buffer arms a transfer. The transfer begins once the enable bit is set. At the start of a transfer the transmit byte is copied into an internal shift register, so the next byte can be written while the current one is still on the wire. Each received byte is first assembled in that shift register. It is then copied into the receive buffer, and a full flag is raised.

In master mode the serial clock is the system clock divided by four, and it rests low between transfers. Data is sampled when the clock rises and changed when it falls. Before the first bit is driven, a programmable wait of 8, 16, 24 or 32 system clocks is inserted. A slave skips that wait. It drives its first bit as soon as the transfer starts, then follows the edges of the external clock, which it passes through a synchronizer first.

The register port has no handshake. Every read or write completes in the cycle in which it is presented, so there is no back-pressure. The serial pins are plain levels.

Top module: `spi_dly_ctrl`

## Requirements
- R1: After reset every register reads zero, and both `sdo` and `sclk_o` are low. `sdo` stays low whenever no transfer is in progress.
- R2: Control bit 7 selects the bit order. 0 sends and receives the most significant bit first, with the shift register moving left. 1 sends the least significant bit first, with the shift register moving right.
- R3: In master mode, control bits 6:5 set the delay before the first bit. Codes 00, 01, 10 and 11 give 8, 16, 24 and 32 system clocks. `sdo` carries the first bit 8·(code+1)+1 clock edges after the edge that wrote the transmit buffer. `sclk_o` stays low during the wait.
- R4: In slave mode (control bit 3 = 0) the delay field has no effect. The first bit appears on `sdo` on the edge after the transfer starts.
- R5: Writing the transmit buffer (address 1) arms a transfer. It starts only while the enable bit (control bit 4) is 1. While the enable bit is 0 the pins stay idle, and the busy bit (status bit 1) stays 0.
- R6: In master mode `sclk_o` runs at one quarter of the system clock and gives exactly eight high pulses per byte. In slave mode `sclk_o` stays low.
- R7: When the eighth bit is sampled, the received byte is written into the receive buffer (address 0), and the full flag (status bit 0) is set on that same edge.
- R8: A read of the receive buffer clears the full flag and the overrun flag. If a byte completes in that same cycle, the completing byte takes priority.
- R9: If a byte completes while the full flag is already set, the receive buffer is overwritten and the overrun flag (status bit 2) is set.
- R10: The transmit buffer is copied into the shift register when a transfer starts. A byte written during a transfer is sent by the next transfer, which starts without further action.
- R11: Addresses 0, 1 and 2 select the receive buffer, the transmit buffer and control/status. Writes to address 0 and to status bits 2:0 are ignored. Control bit 3 = 1 selects master mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of address 0 clears the flags) |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| sclk_i | input | 1 | Serial clock from an external master (slave mode) |
| sdi | input | 1 | Serial data in |
| sclk_o | output | 1 | Generated serial clock (master mode), low otherwise |
| sdo | output | 1 | Serial data out, low when idle |

## Verification
Master transfers run with `sdo` looped back to `sdi`, using bytes such as 0x1E that are not bit palindromes. The order seen on `sclk_o` rising edges shows whether the bit order is right, and the byte returned through the receive buffer shows whether sampling is right. Each delay code is measured against the clock edge that armed the transfer, which would expose an off-by-one in the wait counter. The slave runs are driven with the largest delay code, so any wait that wrongly applies to a slave changes the first-bit timing. Two back-to-back master bytes with no read in between show the pre-loaded second byte being sent, the receive buffer being overwritten and the overrun flag being set.

// File: rtl/spi_dly_pkg.sv
package spi_dly_pkg;
  localparam int AW = 2;
  localparam logic [AW-1:0] ADDR_RX  = 2'd0;
  localparam logic [AW-1:0] ADDR_TX  = 2'd1;
  localparam logic [AW-1:0] ADDR_CTL = 2'd2;

  typedef enum logic [1:0] {ST_IDLE, ST_DELAY, ST_SHIFT} shf_state_e;

  typedef struct packed {
    logic       lsb;
    logic [1:0] dly;
    logic       en;
    logic       mst;
  } ctl_t;
endpackage

// File: rtl/spi_dly_regs.sv
module spi_dly_regs
  import spi_dly_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          start,
  input  logic          rx_load,
  input  logic [DW-1:0] rx_data,
  input  logic          busy,
  output ctl_t          ctl,
  output logic [DW-1:0] txbuf,
  output logic          pend,
  output logic          full,
  output logic          ovr
);
  logic [DW-1:0] rxbuf;
  logic [7:0]    status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txbuf <= '0;
      pend  <= 1'b0;
      ctl   <= '0;
      rxbuf <= '0;
      full  <= 1'b0;
      ovr   <= 1'b0;
    end else begin
      // a new write keeps the arm request alive even if a start is taken now
      if (wr && addr == ADDR_TX) begin
        txbuf <= wdata;
        pend  <= 1'b1;
      end else if (start) begin
        pend <= 1'b0;
      end
      if (wr && addr == ADDR_CTL) begin
        ctl.lsb <= wdata[7];
        ctl.dly <= wdata[6:5];
        ctl.en  <= wdata[4];
        ctl.mst <= wdata[3];
      end
      // a completing byte wins over a clearing read
      if (rx_load) begin
        rxbuf <= rx_data;
        full  <= 1'b1;
        ovr   <= ovr | full;
      end else if (rd && addr == ADDR_RX) begin
        full <= 1'b0;
        ovr  <= 1'b0;
      end
    end
  end

  assign status = {ctl.lsb, ctl.dly, ctl.en, ctl.mst, ovr, busy, full};

  always_comb begin
    rdata = '0;
    unique case (addr)
      ADDR_RX:  rdata = rxbuf;
      ADDR_TX:  rdata = txbuf;
      ADDR_CTL: rdata[7:0] = status;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_dly_clkgen.sv
module spi_dly_clkgen #(
  parameter int DIV  = 4,
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mst,
  input  logic run,
  input  logic sclk_in,
  output logic sclk_o,
  output logic rise,
  output logic fall
);
  localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int HALF = DIV / 2;

  logic [CW-1:0] dc;
  logic [SYNC:0] sy;
  logic          m_rise, m_fall, s_rise, s_fall;

  // master divider: low half then high half, parked at zero when not shifting
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  dc <= '0;
    else if (!run || !mst)       dc <= '0;
    else if (dc == CW'(DIV - 1)) dc <= '0;
    else                         dc <= dc + 1'b1;
  end

  // slave clock synchronizer plus one history stage for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sy <= '0;
    else        sy <= {sy[SYNC-1:0], sclk_in};
  end

  assign m_rise = run && (dc == CW'(HALF - 1));
  assign m_fall = run && (dc == CW'(DIV - 1));
  assign s_rise = sy[SYNC-1] & ~sy[SYNC];
  assign s_fall = ~sy[SYNC-1] & sy[SYNC];

  assign rise   = mst ? m_rise : s_rise;
  assign fall   = mst ? m_fall : s_fall;
  assign sclk_o = mst && (dc >= CW'(HALF));
endmodule

// File: rtl/spi_dly_shifter.sv
module spi_dly_shifter
  import spi_dly_pkg::*;
#(
  parameter int DW       = 8,
  parameter int DLY_UNIT = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctl_t          ctl,
  input  logic          pend,
  input  logic [DW-1:0] txbuf,
  input  logic          rise,
  input  logic          fall,
  input  logic          sdi,
  output logic          start,
  output logic          run,
  output logic          busy,
  output logic          sdo,
  output logic          rx_load,
  output logic [DW-1:0] rx_data
);
  localparam int BW  = $clog2(DW + 1);
  localparam int DCW = $clog2(DLY_UNIT * 4);

  shf_state_e     state;
  logic [DW-1:0]  sh;
  logic [BW-1:0]  bcnt;
  logic [DCW-1:0] dcnt;
  logic           lsb_q;
  logic           sdo_q;
  logic [DW-1:0]  shifted;
  logic           next_bit;
  logic [DCW-1:0] dly_load;

  assign start    = (state == ST_IDLE) && ctl.en && pend;
  assign run      = (state == ST_SHIFT);
  assign busy     = (state != ST_IDLE);
  assign shifted  = lsb_q ? {sdi, sh[DW-1:1]} : {sh[DW-2:0], sdi};
  assign next_bit = lsb_q ? sh[0] : sh[DW-1];
  assign dly_load = DCW'((int'(ctl.dly) + 1) * DLY_UNIT - 1);
  assign rx_load  = run && rise && (bcnt == BW'(DW - 1));
  assign rx_data  = shifted;
  assign sdo      = sdo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      sh    <= '0;
      bcnt  <= '0;
      dcnt  <= '0;
      lsb_q <= 1'b0;
      sdo_q <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            sh    <= txbuf;
            lsb_q <= ctl.lsb;
            bcnt  <= '0;
            if (ctl.mst) begin
              state <= ST_DELAY;
              dcnt  <= dly_load;
              sdo_q <= 1'b0;
            end else begin
              state <= ST_SHIFT;
              sdo_q <= ctl.lsb ? txbuf[0] : txbuf[DW-1];
            end
          end
        end
        ST_DELAY: begin
          if (dcnt == '0) begin
            state <= ST_SHIFT;
            sdo_q <= next_bit;
          end else begin
            dcnt <= dcnt - 1'b1;
          end
        end
        ST_SHIFT: begin
          if (rise && bcnt != BW'(DW)) begin
            sh   <= shifted;
            bcnt <= bcnt + 1'b1;
          end
          if (fall) begin
            if (bcnt == BW'(DW)) begin
              state <= ST_IDLE;
              sdo_q <= 1'b0;
            end else begin
              sdo_q <= next_bit;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_dly_ctrl.sv
module spi_dly_ctrl
  import spi_dly_pkg::*;
#(
  parameter int DW       = 8,
  parameter int DIV      = 4,
  parameter int SYNC     = 2,
  parameter int DLY_UNIT = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          sclk_i,
  input  logic          sdi,
  output logic          sclk_o,
  output logic          sdo
);
  ctl_t          ctl;
  logic [DW-1:0] txbuf, rx_data;
  logic          pend, full, ovr, start, run, busy, rx_load, rise, fall;

  spi_dly_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .start(start), .rx_load(rx_load),
    .rx_data(rx_data), .busy(busy), .ctl(ctl), .txbuf(txbuf), .pend(pend),
    .full(full), .ovr(ovr)
  );

  spi_dly_clkgen #(.DIV(DIV), .SYNC(SYNC)) u_clk (
    .clk(clk), .rst_n(rst_n), .mst(ctl.mst), .run(run), .sclk_in(sclk_i),
    .sclk_o(sclk_o), .rise(rise), .fall(fall)
  );

  spi_dly_shifter #(.DW(DW), .DLY_UNIT(DLY_UNIT)) u_shf (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .pend(pend), .txbuf(txbuf),
    .rise(rise), .fall(fall), .sdi(sdi), .start(start), .run(run),
    .busy(busy), .sdo(sdo), .rx_load(rx_load), .rx_data(rx_data)
  );
endmodule

// File: rtl/spi_dly_ctrl_chk.sv
module spi_dly_ctrl_chk
  import spi_dly_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          sdo,
  input logic          sclk_o,
  input ctl_t          ctl,
  input logic          rx_load,
  input logic          full,
  input logic          ovr,
  input logic          reg_rd,
  input logic [AW-1:0] reg_addr
);
  assert_idle_sdo_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sdo);

  assert_idle_sclk_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk_o);

  assert_slave_no_clock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.mst |-> !sclk_o);

  assert_no_start_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.en && !busy) |=> !busy);

  assert_load_sets_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_load |=> full);

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == ADDR_RX && !rx_load) |=> (!full && !ovr));

  assert_overrun_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_load && full) |=> ovr);
endmodule

bind spi_dly_ctrl spi_dly_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .sdo(sdo), .sclk_o(sclk_o),
  .ctl(ctl), .rx_load(rx_load), .full(full), .ovr(ovr),
  .reg_rd(reg_rd), .reg_addr(reg_addr)
);

// File: tb/spi_dly_ctrl_tb.sv
`timescale 1ns/1ps
module spi_dly_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       sclk_i = 1'b0, sdi_drv = 1'b0, loop_en = 1'b0;
  logic       sdi, sclk_o, sdo;

  int checks = 0, fails = 0;
  bit finished = 0;

  logic [7:0] mon_seq = '0;
  int         mon_cnt = 0;
  time        t_last = 0, t_prev = 0;

  assign sdi = loop_en ? sdo : sdi_drv;

  always #4 clk = ~clk;

  spi_dly_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sclk_i(sclk_i), .sdi(sdi), .sclk_o(sclk_o), .sdo(sdo)
  );

  // observe the bits that a downstream slave would capture
  always @(posedge sclk_o) begin
    mon_seq = {mon_seq[6:0], sdo};
    mon_cnt++;
    t_prev = t_last;
    t_last = $time;
  end

  function automatic logic [7:0] rev8(input logic [7:0] v);
    for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", what, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(posedge clk);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  // counts negedges after the arming write until sdo goes high
  task automatic first_bit_wait(output int cnt, output bit clk_seen);
    cnt = 0; clk_seen = 0;
    while (!sdo && cnt < 200) begin
      @(negedge clk);
      cnt++;
      if (sclk_o) clk_seen = 1;
    end
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd_reg(2'd2, v); chk(v, 8'h00, "R1 status after reset");
    rd_reg(2'd0, v); chk(v, 8'h00, "R1 rx buffer after reset");
    rd_reg(2'd1, v); chk(v, 8'h00, "R1 tx buffer after reset");
    chk(sdo, 0, "R1 sdo idle");
    chk(sclk_o, 0, "R1 sclk idle");
  endtask

  task automatic t_regmap();
    logic [7:0] v;
    wr_reg(2'd2, 8'hFF);
    rd_reg(2'd2, v); chk(v, 8'hF8, "R11 read-only status bits ignore writes");
    wr_reg(2'd0, 8'h77);
    rd_reg(2'd0, v); chk(v, 8'h00, "R11 write to rx buffer ignored");
    wr_reg(2'd2, 8'h00);
  endtask

  task automatic t_enable();
    logic [7:0] v;
    bit seen = 0;
    wr_reg(2'd1, 8'hA5);
    rd_reg(2'd1, v); chk(v, 8'hA5, "R11 tx buffer readback");
    repeat (40) begin
      @(negedge clk);
      if (sdo || sclk_o) seen = 1;
    end
    chk(seen, 0, "R5 pins idle while disabled");
    rd_reg(2'd2, v); chk(v[1], 0, "R5 busy stays low while disabled");
    loop_en = 1'b1;
    wr_reg(2'd2, 8'h18);
    repeat (60) @(negedge clk);
    rd_reg(2'd2, v); chk(v[0], 1, "R7 full after enabled transfer");
    rd_reg(2'd0, v); chk(v, 8'hA5, "R5 armed byte sent once enabled");
  endtask

  task automatic t_delay(input logic [1:0] code, input logic [7:0] b);
    logic [7:0] v;
    int cnt;
    bit seen;
    loop_en = 1'b1;
    wr_reg(2'd2, {1'b0, code, 1'b1, 1'b1, 3'b000});
    mon_cnt = 0;
    wr_reg(2'd1, b);
    first_bit_wait(cnt, seen);
    chk(cnt, 8 * (code + 1) + 1, "R3 master output delay");
    chk(seen, 0, "R3 sclk low during delay");
    repeat (40) @(negedge clk);
    chk(mon_cnt, 8, "R6 eight clock pulses");
    chk(32'(t_last - t_prev), 32, "R6 clock period four system clocks");
    chk(sclk_o, 0, "R6 clock idles low");
    chk(mon_seq, b, "R2 msb-first order on wire");
    rd_reg(2'd2, v); chk(v[0], 1, "R7 full flag set");
    rd_reg(2'd0, v); chk(v, b, "R7 received byte");
    rd_reg(2'd2, v); chk(v[0], 0, "R8 full cleared by read");
  endtask

  task automatic t_order(input bit lsb, input logic [7:0] b);
    logic [7:0] v;
    loop_en = 1'b1;
    wr_reg(2'd2, {lsb, 2'b00, 1'b1, 1'b1, 3'b000});
    mon_cnt = 0;
    wr_reg(2'd1, b);
    repeat (60) @(negedge clk);
    chk(mon_seq, lsb ? rev8(b) : b, "R2 wire bit order");
    rd_reg(2'd0, v); chk(v, b, "R2 received byte in chosen order");
  endtask

  task automatic t_overrun();
    logic [7:0] v;
    loop_en = 1'b1;
    wr_reg(2'd2, 8'h18);
    wr_reg(2'd1, 8'h3C);
    repeat (3) @(negedge clk);
    wr_reg(2'd1, 8'h5A);
    repeat (120) @(negedge clk);
    rd_reg(2'd2, v); chk(v, 8'h1D, "R9 overrun and full set");
    rd_reg(2'd0, v); chk(v, 8'h5A, "R10 preloaded byte sent next");
    rd_reg(2'd2, v); chk(v, 8'h18, "R8 overrun cleared by read");
  endtask

  task automatic t_slave(input bit lsb, input logic [7:0] tx, input logic [7:0] rx);
    logic [7:0] v, seq;
    int cnt;
    bit seen;
    bit clk_any = 0;
    loop_en = 1'b0;
    seq = '0;
    wr_reg(2'd2, {lsb, 2'b11, 1'b1, 1'b0, 3'b000});
    wr_reg(2'd1, tx);
    first_bit_wait(cnt, seen);
    chk(cnt, 1, "R4 slave ignores delay");
    for (int i = 0; i < 8; i++) begin
      sdi_drv = lsb ? rx[i] : rx[7-i];
      repeat (6) @(negedge clk);
      seq = {seq[6:0], sdo};
      sclk_i = 1'b1;
      repeat (6) begin
        @(negedge clk);
        if (sclk_o) clk_any = 1;
      end
      sclk_i = 1'b0;
    end
    repeat (8) @(negedge clk);
    chk(seq, lsb ? rev8(tx) : tx, "R2 slave wire order");
    chk(clk_any, 0, "R6 no generated clock in slave mode");
    chk(sdo, 0, "R1 sdo low after slave transfer");
    rd_reg(2'd2, v); chk(v[0], 1, "R7 slave full flag");
    rd_reg(2'd0, v); chk(v, rx, "R7 slave received byte");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regmap();
    t_enable();
    t_delay(2'b00, 8'h81);
    t_delay(2'b01, 8'h9C);
    t_delay(2'b10, 8'hF0);
    t_delay(2'b11, 8'hC5);
    t_order(1'b0, 8'h1E);
    t_order(1'b1, 8'h1E);
    t_overrun();
    t_slave(1'b0, 8'hB4, 8'h6D);
    t_slave(1'b1, 8'h01, 8'h6D);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule